// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel for a 16-bit timer/counter. It holds a compare value, checks it against the count supplied by the counter on every timer tick, and when the two are equal it raises a sticky match flag, an interrupt request (when enabled), a one-cycle match pulse, and optionally toggles an output pin. The counter, the full waveform mode table and the interrupt controller are outside the block. The counter reports its TOP and BOTTOM events as strobes, and the block reports back the value it should wrap at.

Software reaches the 16-bit value over an 8-bit bus. The upper byte is parked in a holding byte and the whole word is committed when the lower byte is written. In PWM operation the committed word lands in a shadow buffer and moves into the active compare register only on a counter update strobe. The strobe is TOP or BOTTOM, picked by a select input. Outside PWM the word goes straight into the active register. When the channel is chosen as the wrap source, its active value is offered as the counter's TOP.

Top module: `tmr_cmp_unit`

## Requirements
- R1: A synchronous reset (`rst` high) clears the active compare value, the buffer, the holding byte, the flag, the match pulse and the output pin to 0.
- R2: A bus write to address 1 stores the data in the holding byte and changes neither the active value nor the buffer. A bus write to address 0 commits the word {holding byte, data}: the holding byte is the upper 8 bits and the data is the lower 8 bits.
- R3: With `pwm_mode` low, a commit (address 0 write) appears on `cmp_act` and on `cmp_buf` in the next cycle, and `upd_top` and `upd_bottom` have no effect on `cmp_act`.
- R4: With `pwm_mode` high, a commit goes to `cmp_buf` only. `cmp_act` takes the buffer's value from before that clock edge at an edge where the selected strobe is high, where `upd_sel`=0 selects `upd_top` and `upd_sel`=1 selects `upd_bottom`. The unselected strobe has no effect.
- R5: When `tmr_tick` is high and `count` equals `cmp_act` at a clock edge, `match` is high and `flag` is set in the following cycle. Equality without `tmr_tick` does neither.
- R6: `irq` is high exactly when `flag` is high and `irq_en` is high.
- R7: `flag` clears on `irq_ack`, or on a bus write to address 2 with data bit 0 equal to 1. A write to address 2 with bit 0 equal to 0 leaves it unchanged.
- R8: If a match and a clear fall on the same edge, the flag is set.
- R9: On a match, `oc_pin` inverts when `com_mode` is 2'b01. It holds its value for every other `com_mode` value and whenever there is no match.
- R10: `top_val` equals `cmp_act` when `top_sel` is high and is all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | 0 low byte/commit, 1 high byte, 2 flag |
| bus_wdata | input | 8 | Bus write data |
| pwm_mode | input | 1 | 1 selects buffered (PWM) operation |
| upd_sel | input | 1 | 0 loads on TOP, 1 loads on BOTTOM |
| upd_top | input | 1 | Counter reached TOP |
| upd_bottom | input | 1 | Counter reached BOTTOM |
| tmr_tick | input | 1 | Timer clock enable |
| count | input | 16 | Counter value |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| com_mode | input | 2 | Output action, 2'b01 toggles |
| top_sel | input | 1 | Channel supplies TOP |
| cmp_act | output | 16 | Active compare value |
| cmp_buf | output | 16 | Buffered compare value |
| match | output | 1 | Registered match pulse |
| flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| oc_pin | output | 1 | Compare output pin |
| top_val | output | 16 | Wrap value for the counter |

## Verification
A match can set the flag on the same edge that software or the interrupt acknowledge clears it. The bench makes this collision common by steering `count` onto the active value on most ticks while it issues flag writes and acknowledges at random. A behavioural model, in which set overrides clear, judges every cycle. A buffered commit can also meet an update strobe on the same edge. In that case the model expects the active register to take the old buffer contents.

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [7:0]   bus_wdata,
  input  logic         pwm_mode,
  input  logic         upd_sel,
  input  logic         upd_top,
  input  logic         upd_bottom,
  input  logic         tmr_tick,
  input  logic [W-1:0] count,
  input  logic         irq_en,
  input  logic         irq_ack,
  input  logic [1:0]   com_mode,
  input  logic         top_sel,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] cmp_buf,
  output logic         match,
  output logic         flag,
  output logic         irq,
  output logic         oc_pin,
  output logic [W-1:0] top_val
);
  localparam int HW = W - 8;

  logic [HW-1:0] hold;
  logic wr_lo, wr_hi, clr, hit, upd;
  logic [W-1:0] word;

  assign wr_lo = bus_we && bus_addr == 2'd0;
  assign wr_hi = bus_we && bus_addr == 2'd1;
  assign clr   = irq_ack || (bus_we && bus_addr == 2'd2 && bus_wdata[0]);
  assign hit   = tmr_tick && count == cmp_act;
  assign upd   = pwm_mode && (upd_sel ? upd_bottom : upd_top);
  assign word  = {hold, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_hi) hold <= bus_wdata[HW-1:0];
      if (wr_lo) cmp_buf <= word;
      if (!pwm_mode && wr_lo) cmp_act <= word;
      else if (upd) cmp_act <= cmp_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match  <= 1'b0;
      flag   <= 1'b0;
      oc_pin <= 1'b0;
    end else begin
      match <= hit;
      if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (hit && com_mode == 2'b01) oc_pin <= ~oc_pin;
    end
  end

  assign irq     = flag && irq_en;
  assign top_val = top_sel ? cmp_act : '1;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && count == cmp_act) |=> flag);

  a_r5_flag_cause: assert property (@(posedge clk) disable iff (rst)
    (!flag && !(tmr_tick && count == cmp_act)) |=> !flag);

  a_r6_no_irq_idle: assert property (@(posedge clk) disable iff (rst)
    !flag |-> !irq);

  a_r4_pwm_hold: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !(upd_sel ? upd_bottom : upd_top)) |=> $stable(cmp_act));

  a_r3_direct_hold: assert property (@(posedge clk) disable iff (rst)
    (!pwm_mode && !(bus_we && bus_addr == 2'd0)) |=> $stable(cmp_act));

  a_r9_pin_hold: assert property (@(posedge clk) disable iff (rst)
    (com_mode != 2'b01) |=> $stable(oc_pin));

  a_r2_hi_only: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd1) |=> $stable(cmp_buf));
endmodule

// File: tb/tmr_cmp_unit_bench.sv
module tmr_cmp_unit_bench;
  logic clk = 0, rst = 1;
  logic bus_we = 0; logic [1:0] bus_addr = 0; logic [7:0] bus_wdata = 0;
  logic pwm_mode = 0, upd_sel = 0, upd_top = 0, upd_bottom = 0, tmr_tick = 0;
  logic [15:0] count = 0;
  logic irq_en = 0, irq_ack = 0, top_sel = 0;
  logic [1:0] com_mode = 0;
  logic [15:0] cmp_act, cmp_buf, top_val;
  logic match, flag, irq, oc_pin;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_act = 0, m_buf = 0;
  logic [7:0] m_hold = 0;
  logic m_match = 0, m_flag = 0, m_oc = 0;

  always #10 clk = ~clk;

  tmr_cmp_unit u_tmr_cmp_unit (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(bit in_reset);
    chk(in_reset ? "R1 act" : "R3/R4 act", cmp_act, m_act);
    chk(in_reset ? "R1 buf" : "R2 buf", cmp_buf, m_buf);
    chk(in_reset ? "R1 match" : "R5 match", {15'd0, match}, {15'd0, m_match});
    chk(in_reset ? "R1 flag" : "R7/R8 flag", {15'd0, flag}, {15'd0, m_flag});
    chk("R6 irq", {15'd0, irq}, {15'd0, m_flag & irq_en});
    chk(in_reset ? "R1 oc" : "R9 oc", {15'd0, oc_pin}, {15'd0, m_oc});
    chk("R10 top", top_val, top_sel ? m_act : 16'hFFFF);
  endtask

  task automatic model_step();
    logic hit, upd, clr;
    logic [15:0] word;
    if (rst) begin
      m_act = 0; m_buf = 0; m_hold = 0; m_match = 0; m_flag = 0; m_oc = 0;
      return;
    end
    hit  = tmr_tick && count == m_act;
    upd  = pwm_mode && (upd_sel ? upd_bottom : upd_top);
    clr  = irq_ack || (bus_we && bus_addr == 2 && bus_wdata[0]);
    word = {m_hold, bus_wdata};
    m_match = hit;
    if (hit) m_flag = 1; else if (clr) m_flag = 0;
    if (hit && com_mode == 2'b01) m_oc = ~m_oc;
    if (!pwm_mode && bus_we && bus_addr == 0) m_act = word;
    else if (upd) m_act = m_buf;
    if (bus_we && bus_addr == 0) m_buf = word;
    if (bus_we && bus_addr == 1) m_hold = bus_wdata;
  endtask

  task automatic randomize_inputs();
    int r;
    bus_we    = ($urandom % 3) == 0;
    bus_addr  = 2'($urandom % 3);
    bus_wdata = 8'($urandom);
    upd_top   = ($urandom % 5) == 0;
    upd_bottom = ($urandom % 5) == 0;
    tmr_tick  = ($urandom % 2) == 0;
    r = $urandom % 4;
    count     = (r < 2) ? m_act : (r == 2 ? m_act + 16'd1 : 16'($urandom));
    irq_en    = ($urandom % 2) == 0;
    irq_ack   = ($urandom % 6) == 0;
    com_mode  = 2'($urandom % 4);
    top_sel   = ($urandom % 2) == 0;
    if (($urandom % 64) == 0) pwm_mode = ~pwm_mode;
    if (($urandom % 64) == 0) upd_sel = ~upd_sel;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all(rst);
      randomize_inputs();
      @(posedge clk);
      model_step();
    end
  endtask

  initial begin
    @(posedge clk); model_step();
    @(posedge clk); model_step();
    @(negedge clk); compare_all(1);
    rst = 0;
    @(posedge clk); model_step();
    run_cycles(4000);
    @(negedge clk); rst = 1;
    @(posedge clk); model_step();
    @(negedge clk); compare_all(1);
    rst = 0;
    pwm_mode = 1;
    @(posedge clk); model_step();
    run_cycles(4000);
    @(negedge clk); compare_all(0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule